// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block paces the digital side of a successive-approximation converter. A start request launches a fixed-length acquisition window, a hold strobe, and then a bit-by-bit search. In each slot the block drives a trial code onto its DAC port, reads back one comparator bit, and keeps or drops the bit under test. The comparator and the DAC sit outside the block. The slots are deliberately uneven: the two most significant bits get extra settling time, while every lower bit is resolved on a single clock.

A conversion ends with a one-cycle transfer slot. In that slot the search register is converted to two's complement and written into one of two result registers. In paired mode the first result lands in the first register with no completion pulse, a second search starts at once with no new acquisition, and its result goes into the second register. A busy flag covers the whole request. An abort input drops everything, and a new start restarts the sequence from acquisition.

Top module: `sar_conv_sequencer`

## Requirements
- R1: After reset, busy_o and done_o are low and both result registers read zero.
- R2: A start sampled on clock edge E0 gives four clocks of acquisition. hold_o is high for exactly one cycle, the cycle after edge E0+4, and during that cycle dac_o shows the mid-scale trial 0x200 (only bit 9 set).
- R3: The top bit is decided on edge E0+7 (hold, plus two settling cycles) and the next bit on edge E0+9. Each lower bit is decided on each following edge. A comparator value of 1 keeps the bit under test, and 0 clears it. After each decision dac_o shows the kept bits with the next lower bit set.
- R4: A single conversion ends with a done_o pulse of exactly one cycle, the cycle after edge E0+18 (14 cycles after hold). At that edge the first result register is loaded. done_o is low before that.
- R5: Stored results are two's complement: the bit 9 of the final search code is inverted. An input at mid-scale reads 0x000, positive full scale reads 0x1FF, and negative full scale reads 0x200.
- R6: With dbl_i high at the start, the first result is stored at edge E0+18 without a done pulse and with busy_o held high. A second search follows with no hold pulse. Its result is stored in the second register, with done_o, at edge E0+32.
- R7: busy_o is high from the cycle after the start edge until the edge that raises done_o, and it is low while done_o is high.
- R8: abort_i sampled high returns the block to idle at that edge. busy_o is low, no done_o follows, and both result registers keep their values.
- R9: A start while busy restarts acquisition from that edge. The interrupted conversion stores nothing and gives no done_o.
- R10: A single-mode conversion leaves the second result register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start (or restart) request, sampled on a rising edge |
| dbl_i | input | 1 | Paired-conversion select, captured with start_i |
| abort_i | input | 1 | Abort; overrides start_i |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the trial code |
| dac_o | output | 10 | Trial code in offset binary |
| hold_o | output | 1 | One-cycle strobe at the end of acquisition |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| res1_o | output | 10 | First result, two's complement |
| res2_o | output | 10 | Second result, two's complement |

## Verification
The bench drives the three codes that sit on the coding boundaries (mid-scale, both full scales) and alternating-bit patterns. A design that forgets the MSB inversion, or that drops the last bit decision, reads back the wrong code at once. It probes the trial code right after the hold edge and after each of the two long settling slots. An off-by-one in the uneven slot lengths shifts those values and moves done_o away from the expected edge. The bench also checks paired mode: a design that pulses done or re-acquires after the first result, or that writes the wrong register, is caught there. Abort and restart are hit mid-search. A leftover write or a stray done pulse from the interrupted conversion shows up as a changed register or an unexpected pulse.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACQ   = 2'd1,
        ST_CONV  = 2'd2,
        ST_STORE = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       dbl;
        logic       second;
        logic       done;
        logic       hold;
    } seq_regs_t;

endpackage

// File: rtl/sar_slot_timer.sv
module sar_slot_timer #(
    parameter int LW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [LW-1:0] len,
    output logic          last_o
);
    logic [LW-1:0] cnt_d, cnt_q;

    always_comb begin
        last_o = en && (cnt_q == len - LW'(1));
        cnt_d  = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (en)
            cnt_d = last_o ? '0 : cnt_q + LW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |-> (cnt_q < len));

endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
    parameter int NBITS = 10,
    localparam int BW = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             init,
    input  logic             decide,
    input  logic             cmp_i,
    output logic [NBITS-1:0] code_o,
    output logic [BW-1:0]    bit_o,
    output logic             last_bit_o
);
    localparam logic [BW-1:0] TOP = BW'(NBITS - 1);

    typedef struct packed {
        logic [NBITS-1:0] sar;
        logic [BW-1:0]    idx;
    } sar_regs_t;

    sar_regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.sar = '0;
            s_d.idx = TOP;
        end else if (init) begin
            s_d.sar      = '0;
            s_d.sar[TOP] = 1'b1;
            s_d.idx      = TOP;
        end else if (decide) begin
            if (!cmp_i)
                s_d.sar[s_q.idx] = 1'b0;
            if (s_q.idx != '0) begin
                s_d.sar[s_q.idx - BW'(1)] = 1'b1;
                s_d.idx = s_q.idx - BW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{sar: '0, idx: TOP};
        else        s_q <= s_d;
    end

    assign code_o     = s_q.sar;
    assign bit_o      = s_q.idx;
    assign last_bit_o = (s_q.idx == '0);

    // R3
    decide_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && !clr && !init && s_q.idx != '0) |=> (s_q.idx == $past(s_q.idx) - BW'(1)));

endmodule

// File: rtl/sar_result_bank.sv
module sar_result_bank #(
    parameter int NBITS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             sel,
    input  logic [NBITS-1:0] code_ob,
    output logic [NBITS-1:0] res1_o,
    output logic [NBITS-1:0] res2_o
);
    typedef struct packed {
        logic [NBITS-1:0] r1;
        logic [NBITS-1:0] r2;
    } bank_t;

    bank_t b_d, b_q;
    logic [NBITS-1:0] code_tc;

    always_comb begin
        code_tc = {~code_ob[NBITS-1], code_ob[NBITS-2:0]};
        b_d = b_q;
        if (wr) begin
            if (sel) b_d.r2 = code_tc;
            else     b_d.r1 = code_tc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign res1_o = b_q.r1;
    assign res2_o = b_q.r2;

    // R8
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ($stable(res1_o) && $stable(res2_o)));

endmodule

// File: rtl/sar_conv_sequencer.sv
module sar_conv_sequencer
    import sar_seq_pkg::*;
#(
    parameter int NBITS       = 10,
    parameter int ACQ_CYC     = 4,
    parameter int MSB_SETTLE  = 2,
    parameter int MSB2_SETTLE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             dbl_i,
    input  logic             abort_i,
    input  logic             cmp_i,
    output logic [NBITS-1:0] dac_o,
    output logic             hold_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [NBITS-1:0] res1_o,
    output logic [NBITS-1:0] res2_o
);
    localparam int BW      = $clog2(NBITS);
    localparam int MSB_LEN = MSB_SETTLE + 1;
    localparam int MAX_A   = (ACQ_CYC > MSB_LEN) ? ACQ_CYC : MSB_LEN;
    localparam int MAXLEN  = (MAX_A > MSB2_SETTLE) ? MAX_A : MSB2_SETTLE;
    localparam int LW      = $clog2(MAXLEN + 1);
    localparam logic [BW-1:0] TOP  = BW'(NBITS - 1);
    localparam logic [BW-1:0] NEXT = BW'(NBITS - 2);
    localparam logic [NBITS-1:0] MID = {1'b1, {(NBITS-1){1'b0}}};

    seq_regs_t r_d, r_q;

    logic          sar_clr, sar_init, sar_dec, last_bit;
    logic [BW-1:0] bit_idx;
    logic          tmr_clr, tmr_en, tmr_last;
    logic [LW-1:0] slot_len;
    logic          wr;

    always_comb begin
        case (r_q.state)
            ST_ACQ:  slot_len = LW'(ACQ_CYC);
            ST_CONV: slot_len = (bit_idx == TOP)  ? LW'(MSB_LEN) :
                                (bit_idx == NEXT) ? LW'(MSB2_SETTLE) : LW'(1);
            default: slot_len = LW'(1);
        endcase
        tmr_en = (r_q.state != ST_IDLE);
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.hold = 1'b0;
        sar_clr  = 1'b0;
        sar_init = 1'b0;
        sar_dec  = 1'b0;
        tmr_clr  = 1'b0;
        wr       = 1'b0;
        if (abort_i) begin
            r_d.state = ST_IDLE;
            sar_clr   = 1'b1;
            tmr_clr   = 1'b1;
        end else if (start_i) begin
            r_d.state  = ST_ACQ;
            r_d.dbl    = dbl_i;
            r_d.second = 1'b0;
            sar_clr    = 1'b1;
            tmr_clr    = 1'b1;
        end else begin
            case (r_q.state)
                ST_IDLE: tmr_clr = 1'b1;
                ST_ACQ: if (tmr_last) begin
                    r_d.state = ST_CONV;
                    r_d.hold  = 1'b1;
                    sar_init  = 1'b1;
                end
                ST_CONV: if (tmr_last) begin
                    sar_dec = 1'b1;
                    if (last_bit) r_d.state = ST_STORE;
                end
                ST_STORE: if (tmr_last) begin
                    wr = 1'b1;
                    if (r_q.dbl && !r_q.second) begin
                        r_d.state  = ST_CONV;
                        r_d.second = 1'b1;
                        sar_init   = 1'b1;
                    end else begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                        sar_clr   = 1'b1;
                    end
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, dbl: 1'b0, second: 1'b0, done: 1'b0, hold: 1'b0};
        else        r_q <= r_d;
    end

    sar_slot_timer #(.LW(LW)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .en(tmr_en),
        .len(slot_len), .last_o(tmr_last)
    );

    sar_approx_reg #(.NBITS(NBITS)) u_sar (
        .clk(clk), .rst_n(rst_n), .clr(sar_clr), .init(sar_init),
        .decide(sar_dec), .cmp_i(cmp_i), .code_o(dac_o),
        .bit_o(bit_idx), .last_bit_o(last_bit)
    );

    sar_result_bank #(.NBITS(NBITS)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr(wr), .sel(r_q.second),
        .code_ob(dac_o), .res1_o(res1_o), .res2_o(res2_o)
    );

    assign busy_o = (r_q.state != ST_IDLE);
    assign done_o = r_q.done;
    assign hold_o = r_q.hold;

    // R2
    hold_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |=> !hold_o);
    // R2
    hold_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |-> (dac_o == MID));
    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    // R8
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!busy_o && !done_o));

endmodule

// File: tb/tb_sar_conv_sequencer.sv
module tb_sar_conv_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam logic [9:0] MID = 10'h200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, dbl_i = 1'b0, abort_i = 1'b0;
    logic [9:0] tgt = 10'h200;
    logic [9:0] dac_o, res1_o, res2_o;
    logic hold_o, busy_o, done_o, cmp_i;
    int checks = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign cmp_i = (dac_o <= tgt);

    sar_conv_sequencer dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dbl_i(dbl_i),
        .abort_i(abort_i), .cmp_i(cmp_i), .dac_o(dac_o), .hold_o(hold_o),
        .busy_o(busy_o), .done_o(done_o), .res1_o(res1_o), .res2_o(res2_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    // leaves the bench at the falling edge after E0; tc is the two's-complement input
    task automatic launch(input logic [9:0] tc, input logic dbl);
        @(negedge clk);
        tgt = tc ^ MID;
        start_i = 1'b1;
        dbl_i = dbl;
        @(negedge clk);
        start_i = 1'b0;
        dbl_i = 1'b0;
    endtask

    task automatic t_single(input logic [9:0] tc);
        logic [9:0] ob;
        logic [9:0] r2_before;
        int early;
        ob = tc ^ MID;
        r2_before = res2_o;
        early = 0;
        launch(tc, 1'b0);
        chk("R7 busy after start", busy_o, 1);
        adv(3);
        chk("R2 no hold before E4", hold_o, 0);
        adv(1);
        chk("R2 hold after E4", hold_o, 1);
        chk("R2 mid trial", dac_o, MID);
        adv(1);
        chk("R2 hold one cycle", hold_o, 0);
        adv(2);
        chk("R3 trial after MSB decision", dac_o, (ob & 10'h200) | 10'h100);
        adv(1);
        chk("R3 second bit not yet decided", dac_o, (ob & 10'h200) | 10'h100);
        adv(1);
        chk("R3 trial after second decision", dac_o, (ob & 10'h300) | 10'h080);
        for (int i = 0; i < 8; i++) begin
            if (done_o) early++;
            adv(1);
        end
        chk("R4 no early done", early, 0);
        chk("R7 busy before done", busy_o, 1);
        adv(1);
        chk("R4 done pulse", done_o, 1);
        chk("R7 busy low at done", busy_o, 0);
        chk("R5 result code", res1_o, tc);
        chk("R10 second register untouched", res2_o, r2_before);
        adv(1);
        chk("R4 done one cycle", done_o, 0);
    endtask

    task automatic t_double(input logic [9:0] a, input logic [9:0] b);
        int holds;
        launch(a, 1'b1);
        adv(18);
        chk("R6 first result stored", res1_o, a);
        chk("R6 no done after first", done_o, 0);
        chk("R6 busy stays high", busy_o, 1);
        tgt = b ^ MID;
        holds = 0;
        for (int i = 0; i < 13; i++) begin
            if (hold_o || done_o) holds++;
            adv(1);
        end
        chk("R6 no hold or done during second", holds, 0);
        adv(1);
        chk("R6 done after second", done_o, 1);
        chk("R6 second result", res2_o, b);
        chk("R6 first result kept", res1_o, a);
    endtask

    task automatic t_abort();
        logic [9:0] r1, r2;
        int dones;
        r1 = res1_o;
        r2 = res2_o;
        dones = 0;
        launch(10'h0AB, 1'b1);
        adv(7);
        abort_i = 1'b1;
        adv(1);
        abort_i = 1'b0;
        chk("R8 idle after abort", busy_o, 0);
        for (int i = 0; i < 40; i++) begin
            if (done_o) dones++;
            adv(1);
        end
        chk("R8 no done after abort", dones, 0);
        chk("R8 res1 kept", res1_o, r1);
        chk("R8 res2 kept", res2_o, r2);
    endtask

    task automatic t_restart(input logic [9:0] a, input logic [9:0] b);
        int dones;
        dones = 0;
        launch(a, 1'b0);
        adv(9);
        launch(b, 1'b0);
        for (int i = 0; i < 17; i++) begin
            if (done_o) dones++;
            adv(1);
        end
        chk("R9 old conversion gives no done", dones, 0);
        chk("R9 busy during restart", busy_o, 1);
        adv(1);
        chk("R9 done after restart", done_o, 1);
        chk("R9 restarted result", res1_o, b);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        adv(3);
        rst_n = 1'b1;
        adv(1);
        chk("R1 busy reset", busy_o, 0);
        chk("R1 done reset", done_o, 0);
        chk("R1 res1 reset", res1_o, 0);
        chk("R1 res2 reset", res2_o, 0);
        t_single(10'h000);
        t_single(10'h1FF);
        t_single(10'h200);
        t_single(10'h155);
        t_double(10'h2AA, 10'h1FF);
        t_single(10'h0F0);
        t_abort();
        t_restart(10'h011, 10'h3C0);
        adv(2);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule